// File: doc/BRIEF.md
# Serial-Shared GPIO Port Data Register

This block is the data register of an eight-pin general-purpose port whose pins are shared with serial channels. Each pin receives a two-bit mode code from an external pin-function controller and works as a peripheral pin, a driven general output, or a general input with or without a pull-up. A bus write loads the data latch. A bus read returns, bit by bit, either the latch or the synchronized pin level, depending on the pin's mode.

Three pins also carry serial receive data. While a channel's receiver is enabled, its pin is released and a read returns that pin's level whatever mode the controller has selected. This lets software sample the receive lines before it sets up the port. The top pin is input-only. The latch survives a manual reset, and only the power-on reset clears it.

Top module: `sercom_gpio_port`

## Requirements
- R1: A write with `wr_en` high stores `wr_data[6:0]` in the latch at that clock edge. The stored value is visible on `rd_data` from the next cycle for pins in output or peripheral mode.
- R2: Mode code 01 is general output. The pin's `pin_oe` is 1, `pin_out` equals the latch bit, and a read returns the latch bit, never the pin level.
- R3: Mode codes 10 and 11 are general input. A read returns the level of `pin_in`, taken through a two-stage synchronizer, so a change on the pin appears on `rd_data` after the second rising edge.
- R4: `pin_pullup` is 1 exactly for pins in mode 10.
- R5: Mode code 00 is peripheral. Unless a receive override applies, a read returns the latch bit and `pin_oe` is 0.
- R6: An active-low power-on reset (`por_n`) clears the latch to zero.
- R7: A pulse on the manual reset (`mrst_n`) leaves the latch unchanged. It only clears the synchronizer stages.
- R8: Bit 7 is input-only. Writes to it are ignored, its `pin_oe` and `pin_out` stay 0, and it reads as 0 unless its mode is 10 or 11.
- R9: `rx_en[0]`, `rx_en[1]` and `rx_en[2]` govern bits 0, 2 and 4. While one of them is 1, that pin's `pin_oe` is 0 and a read returns its synchronized pin level in every mode.
- R10: Without a write, the latch keeps its value indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low; clears synchronizer only |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Bus read data, per-bit latch or pin level |
| pin_mode | input | 16 | Two bits per pin, pin i at [2i+1:2i]: 00 peripheral, 01 output, 10 input with pull-up, 11 input |
| rx_en | input | 3 | Receive enables of the three serial channels (bits 0, 2, 4) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pullup | output | 8 | Pad pull-up enables |

## Verification
A corrupted latch bit shows on `rd_data` and `pin_out` in the first cycle after it occurs, whenever that pin is in output or peripheral mode. In input mode it stays hidden until the mode changes. A wrong select in the read multiplexer, such as a missed receive override or bit 7 leaking, shows combinationally as soon as the mode or enable is applied. Synchronizer faults appear as a read that arrives one cycle early or late after a pin edge. The bench therefore samples between the first and the second edge after each pin change.

// File: rtl/scport_pkg.sv
package scport_pkg;

   typedef enum logic [1:0] {
      PM_PERIPH = 2'b00,
      PM_OUT    = 2'b01,
      PM_IN_PU  = 2'b10,
      PM_IN_RAW = 2'b11
   } pin_mode_e;

   function automatic int popcnt(input logic [63:0] v);
      int n;
      n = 0;
      for (int k = 0; k < 64; k++) n += int'(v[k]);
      return n;
   endfunction

   // Number of set bits of v strictly below position idx.
   function automatic int rank_below(input logic [63:0] v, input int idx);
      int n;
      n = 0;
      for (int k = 0; k < 64; k++)
         if (k < idx) n += int'(v[k]);
      return n;
   endfunction

endpackage

// File: rtl/scport_sync.sv
module scport_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         mrst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scport_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)       stg[s] <= '0;
            else if (!mrst_n) stg[s] <= '0;
            else if (s == 0)  stg[s] <= d;
            else              stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/scport_latch.sv
module scport_latch #(
   parameter int           W     = 8,
   parameter logic [W-1:0] WMASK = 8'h7F
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     q <= '0;
      else if (wr_en) q <= (q & ~WMASK) | (wr_data & WMASK);
   end

   // R10: no write means the latch holds
   a_r10_latch_hold: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(q));
endmodule

// File: rtl/scport_pinctl.sv
module scport_pinctl
   import scport_pkg::*;
#(
   parameter int           W       = 8,
   parameter logic [W-1:0] RO_MASK = 8'h80,
   parameter logic [W-1:0] RX_MASK = 8'h15,
   parameter int           NRX     = 3
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic [2*W-1:0] mode_vec,
   input  logic [NRX-1:0] rx_en,
   input  logic [W-1:0]   latch,
   input  logic [W-1:0]   pin_sync,
   output logic [W-1:0]   rd_data,
   output logic [W-1:0]   pin_out,
   output logic [W-1:0]   pin_oe,
   output logic [W-1:0]   pin_pullup
);
   generate
      if (popcnt(64'(RX_MASK)) != NRX) begin : g_bad_nrx
         $error("scport_pinctl: NRX must equal the number of RX_MASK bits");
      end
      if ((RO_MASK & RX_MASK) != '0) begin : g_bad_overlap
         $error("scport_pinctl: a pin cannot be both read-only and receive");
      end

      for (genvar i = 0; i < W; i++) begin : g_pin
         pin_mode_e md;
         logic      is_in;
         logic      ovr;
         assign md    = pin_mode_e'(mode_vec[2*i +: 2]);
         assign is_in = (md == PM_IN_PU) || (md == PM_IN_RAW);

         if (RX_MASK[i]) begin : g_rx
            localparam int CH = rank_below(64'(RX_MASK), i);
            assign ovr = rx_en[CH];
         end else begin : g_norx
            assign ovr = 1'b0;
         end

         if (RO_MASK[i]) begin : g_ro
            assign rd_data[i] = is_in ? pin_sync[i] : 1'b0;
            assign pin_oe[i]  = 1'b0;
            // R8: input-only pin is never driven
            a_r8_ro_undriven: assert property (@(posedge clk) disable iff (!por_n)
               !pin_oe[i] && !pin_out[i]);
         end else begin : g_rw
            assign rd_data[i] = (is_in || ovr) ? pin_sync[i] : latch[i];
            assign pin_oe[i]  = (md == PM_OUT) && !ovr;
            // R2: output-mode read matches the driven value
            a_r2_out_reads_latch: assert property (@(posedge clk) disable iff (!por_n)
               (md == PM_OUT && !ovr) |-> (pin_oe[i] && rd_data[i] == pin_out[i]));
         end

         assign pin_out[i]    = pin_oe[i] & latch[i];
         assign pin_pullup[i] = (md == PM_IN_PU);

         // R9: receive override releases the pin
         a_r9_rx_releases: assert property (@(posedge clk) disable iff (!por_n)
            ovr |-> !pin_oe[i]);
      end
   endgenerate
endmodule

// File: rtl/sercom_gpio_port.sv
module sercom_gpio_port #(
   parameter int                NPINS       = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [NPINS-1:0]  RO_MASK     = 8'h80,
   parameter logic [NPINS-1:0]  RX_MASK     = 8'h15,
   parameter int                NRX         = 3
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               mrst_n,
   input  logic               wr_en,
   input  logic [NPINS-1:0]   wr_data,
   output logic [NPINS-1:0]   rd_data,
   input  logic [2*NPINS-1:0] pin_mode,
   input  logic [NRX-1:0]     rx_en,
   input  logic [NPINS-1:0]   pin_in,
   output logic [NPINS-1:0]   pin_out,
   output logic [NPINS-1:0]   pin_oe,
   output logic [NPINS-1:0]   pin_pullup
);
   localparam logic [NPINS-1:0] WMASK = ~RO_MASK;

   generate
      if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
         $error("sercom_gpio_port: NPINS out of range");
      end
   endgenerate

   logic [NPINS-1:0] latch_q;
   logic [NPINS-1:0] pin_sync;

   scport_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .d(pin_in), .q(pin_sync));

   scport_latch #(.W(NPINS), .WMASK(WMASK)) u_latch (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data), .q(latch_q));

   scport_pinctl #(.W(NPINS), .RO_MASK(RO_MASK), .RX_MASK(RX_MASK), .NRX(NRX)) u_pinctl (
      .clk(clk), .por_n(por_n), .mode_vec(pin_mode), .rx_en(rx_en),
      .latch(latch_q), .pin_sync(pin_sync), .rd_data(rd_data),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup));
endmodule

// File: tb/sim_sercom_gpio_port.sv
`timescale 1ns/1ps
module sim_sercom_gpio_port;
   logic        clk = 1'b0;
   logic        por_n = 1'b0, mrst_n = 1'b1, wr_en = 1'b0;
   logic [7:0]  wr_data = '0, pin_in = '0;
   logic [15:0] pin_mode = '0;
   logic [2:0]  rx_en = '0;
   logic [7:0]  rd_data, pin_out, pin_oe, pin_pullup;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   sercom_gpio_port u0 (.clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .pin_mode(pin_mode), .rx_en(rx_en),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup));

   localparam logic [15:0] M_PER = 16'h0000, M_OUT = 16'h5555,
                           M_IPU = 16'hAAAA, M_IRW = 16'hFFFF;

   typedef struct packed {
      logic [15:0] mode; logic [2:0] rx; logic [7:0] pin;
      logic [7:0] rd; logic [7:0] oe; logic [7:0] pu;
   } vec_t;

   // Latch holds 8'h5A during the table walk.
   localparam vec_t VT [8] = '{
      '{M_OUT, 3'b000, 8'hFF, 8'h5A, 8'h7F, 8'h00},  // R2 R8
      '{M_IPU, 3'b000, 8'hC3, 8'hC3, 8'h00, 8'hFF},  // R3 R4
      '{M_IRW, 3'b000, 8'h3C, 8'h3C, 8'h00, 8'h00},  // R3 R4
      '{M_PER, 3'b000, 8'hFF, 8'h5A, 8'h00, 8'h00},  // R5
      '{M_PER, 3'b111, 8'hFF, 8'h5F, 8'h00, 8'h00},  // R9
      '{M_OUT, 3'b010, 8'hFF, 8'h5E, 8'h7B, 8'h00},  // R9
      '{M_IPU, 3'b111, 8'h80, 8'h80, 8'h00, 8'hFF},  // R3 R8
      '{16'h4000, 3'b000, 8'hFF, 8'h5A, 8'h00, 8'h00} // R8
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(3);
      por_n = 1'b1;
      tick(1);
      // R6 reset state
      chk("R6 reset rd", rd_data, 8'h00);
      chk("R6 reset oe", pin_oe, 8'h00);
      // R1 R8 write all ones in output mode
      pin_mode = M_OUT;
      wr_data = 8'hFF; wr_en = 1'b1; tick(1); wr_en = 1'b0;
      chk("R1 write rd", rd_data, 8'h7F);
      chk("R8 pin_out bit7", pin_out, 8'h7F);
      // load table latch value; bit7 of write ignored
      wr_data = 8'hDA; wr_en = 1'b1; tick(1); wr_en = 1'b0;
      chk("R1 R8 write masked", rd_data, 8'h5A);
      for (int v = 0; v < 8; v++) begin
         pin_mode = VT[v].mode; rx_en = VT[v].rx; pin_in = VT[v].pin;
         tick(3);
         chk($sformatf("R2-table v%0d rd", v), rd_data, VT[v].rd);
         chk($sformatf("R9 table v%0d oe", v), pin_oe, VT[v].oe);
         chk($sformatf("R4 table v%0d pu", v), pin_pullup, VT[v].pu);
      end
      rx_en = '0;
      // R3 synchronizer latency
      pin_mode = M_IRW; pin_in = 8'h00; tick(3);
      pin_in = 8'hA5; tick(1);
      chk("R3 one edge old", rd_data, 8'h00);
      tick(1);
      chk("R3 two edges new", rd_data, 8'hA5);
      // R10 hold over idle cycles
      pin_mode = M_OUT; pin_in = 8'h00; tick(20);
      chk("R10 hold", rd_data, 8'h5A);
      chk("R2 pin_out", pin_out, 8'h5A);
      // R7 manual reset keeps latch
      mrst_n = 1'b0; tick(2); mrst_n = 1'b1; tick(1);
      chk("R7 mrst latch", rd_data, 8'h5A);
      // R6 power-on reset clears latch
      por_n = 1'b0; tick(1); por_n = 1'b1; tick(1);
      chk("R6 por clears", rd_data, 8'h00);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule